// File: doc/BRIEF.md
# Dual-Channel Capture Timer

This block is a free-running down-counter with two timestamp channels. While a tick-enable input is high the counter decrements by one per clock. It never stops, and no capture disturbs it. Each channel watches one trigger signal and reacts to a rising or a falling transition, chosen per channel. When the chosen transition is seen, the channel stores the current count in its own capture register and raises a sticky pending flag.

Channel A always watches its external pin. Channel B watches either its external pin or an internal comparator signal, as software selects. A count step from zero wraps the counter to all-ones and raises a separate sticky underflow flag. The underflow flag and channel A's flag share channel A's interrupt enable. An interrupt handler therefore has to read both flags to learn which event, or both, caused the request.

Software reaches the block through a small synchronous register port. Writes go to one control register, which holds the enables, the edge and source selections, and the three flags. Reads return the control register, either capture register or the live count.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset the count decrements by one on every clock with `tick_en` high and holds when `tick_en` is low. Captures never alter it.
- R2: A level change on a trigger input reaches its channel through two synchronizing flops and one previous-sample flop. The capture register and the flag update on the third rising clock edge after the input changes.
- R3: On a detected event, the count held just before that clock edge is copied into the channel's capture register. Input A feeds capture A and input B (or its substitute, see R8) feeds capture B.
- R4: Control bit 1 selects channel A's edge and bit 2 selects channel B's edge, with 0 meaning rising and 1 meaning falling. A transition of the other direction is ignored.
- R5: An event sets the channel's pending flag (bit 4 for A, bit 6 for B). The flag stays set until a control write puts 0 in that bit. When a clear and a new event fall in the same cycle, the flag ends up set.
- R6: A tick while the count is zero loads all-ones and sets the underflow flag in control bit 0. That flag is sticky in the same way as the pending flags.
- R7: `irq` is registered. One cycle after the flags change it equals ((bit 4 or bit 0) and bit 5) or (bit 6 and bit 7), where bit 5 enables A and bit 7 enables B.
- R8: With control bit 3 at 1, channel B takes its events from `cmp_evt`, and activity on `cap_b_pin` has no effect. With bit 3 at 0 the pin is used.
- R9: Address 0 is the control register, address 1 is capture A, address 2 is capture B and address 3 is the count. Only address 0 is writable. `reg_rdata` is registered and shows, one cycle after the address is presented, the value held before that edge, so a capture in the same cycle returns the old value.
- R10: Synchronous reset sets the count to all-ones and clears every control bit, both capture registers, `irq` and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| cap_a_pin | input | 1 | Asynchronous trigger input for channel A |
| cap_b_pin | input | 1 | Asynchronous trigger input for channel B |
| cmp_evt | input | 1 | Internal comparator level, alternative source for channel B |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Write data, low 8 bits used at address 0 |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with an 8-bit counter (`CNT_W = 8`) and a 16-bit register port. With that width the counter passes through zero every 256 ticks, so many underflows and their wrap to all-ones fall within a short run. Repeated wraps also let captures land on both small and wrapped count values. The reference model follows each synchronizer stage, and it is compared against `irq` and the read data on every cycle. This catches any shift in latency, including a flag clear that collides with a new event.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CTRL_W = 8;

  // Bit order is the software-visible layout of the control register.
  typedef struct packed {
    logic en_b;    // 7
    logic pend_b;  // 6
    logic en_a;    // 5
    logic pend_a;  // 4
    logic src_b;   // 3 : 1 = comparator feeds channel B
    logic fall_b;  // 2 : 1 = falling edge
    logic fall_a;  // 1
    logic unf;     // 0 : underflow pending
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CAPA = 2'd1,
    SEL_CAPB = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dct_sync.sv
module dct_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/dct_edge.sv
module dct_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  input  logic fall_sel,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig;
  end

  assign evt = fall_sel ? (prev_q & ~sig) : (~prev_q & sig);
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             unf
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign unf = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '1;
    else if (tick) cnt_q <= cnt_q - ONE;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import dct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cap_a_pin,
  input  logic              cap_b_pin,
  input  logic              cmp_evt,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int NCH = 2;

  logic [CNT_W-1:0]          cnt_q;
  logic                      unf_evt;
  logic [2:0]                sync_q;
  logic [NCH-1:0]            ch_sig;
  logic [NCH-1:0]            ch_fall;
  logic [NCH-1:0]            ch_evt;
  logic [NCH-1:0][CNT_W-1:0] cap_q;
  ctrl_t                     ctrl_q;
  ctrl_t                     ctrl_d;

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_en),
    .cnt  (cnt_q),
    .unf  (unf_evt)
  );

  dct_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cmp_evt, cap_b_pin, cap_a_pin}),
    .q   (sync_q)
  );

  assign ch_sig[0] = sync_q[0];
  assign ch_sig[1] = ctrl_q.src_b ? sync_q[2] : sync_q[1];
  assign ch_fall   = {ctrl_q.fall_b, ctrl_q.fall_a};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] cap_r;

    dct_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .sig      (ch_sig[i]),
      .fall_sel (ch_fall[i]),
      .evt      (ch_evt[i])
    );

    always_ff @(posedge clk) begin
      if (rst)            cap_r <= '0;
      else if (ch_evt[i]) cap_r <= cnt_q;
    end

    assign cap_q[i] = cap_r;
  end

  // Software write first, then event sets, so a set always wins.
  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we && reg_sel_e'(reg_addr) == SEL_CTRL)
      ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    if (ch_evt[0]) ctrl_d.pend_a = 1'b1;
    if (ch_evt[1]) ctrl_d.pend_b = 1'b1;
    if (unf_evt)   ctrl_d.unf    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= ((ctrl_q.pend_a | ctrl_q.unf) & ctrl_q.en_a) |
             (ctrl_q.pend_b & ctrl_q.en_b);
      case (reg_sel_e'(reg_addr))
        SEL_CTRL: reg_rdata <= DATA_W'(ctrl_q);
        SEL_CAPA: reg_rdata <= DATA_W'(cap_q[0]);
        SEL_CAPB: reg_rdata <= DATA_W'(cap_q[1]);
        default:  reg_rdata <= DATA_W'(cnt_q);
      endcase
    end
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             unf_flag,
  input logic             ev_a,
  input logic [CNT_W-1:0] cap_a,
  input logic             pend_a,
  input logic             pend_b,
  input logic             en_b,
  input logic             clr_a,
  input logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == $past(cnt) - ONE);  // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));  // R1
  AST_UNF_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0) |=> (cnt == '1 && unf_flag));  // R6
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    ev_a |=> (cap_a == $past(cnt) && pend_a));  // R3
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_a && !clr_a) |=> pend_a);  // R5
  AST_IRQ_B: assert property (@(posedge clk) disable iff (rst)
    (pend_b && en_b) |=> irq);  // R7
endmodule

bind dual_capture_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick_en),
  .cnt      (cnt_q),
  .unf_flag (ctrl_q.unf),
  .ev_a     (ch_evt[0]),
  .cap_a    (cap_q[0]),
  .pend_a   (ctrl_q.pend_a),
  .pend_b   (ctrl_q.pend_b),
  .en_b     (ctrl_q.en_b),
  .clr_a    (reg_we && reg_addr == 2'd0 && !reg_wdata[4]),
  .irq      (irq)
);

// File: tb/dual_capture_timer_tb.sv
module dual_capture_timer_tb;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 16;
  localparam int MASK   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b0;
  logic              cap_a_pin = 1'b0;
  logic              cap_b_pin = 1'b0;
  logic              cmp_evt = 1'b0;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string label = "R10 reset state";

  always #10 clk = ~clk;  // 50 MHz

  dual_capture_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cap_a_pin(cap_a_pin),
    .cap_b_pin(cap_b_pin), .cmp_evt(cmp_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  // Behavioural reference model, advanced once per rising edge.
  int m_cnt, m_ctrl, m_capa, m_capb, m_rd, m_irq;
  int m_pa, m_pb;
  int m_s1[3];
  int m_s2[3];

  always @(posedge clk) begin
    int ev_a, ev_b, sel_b, unf;
    if (rst) begin
      m_cnt = MASK; m_ctrl = 0; m_capa = 0; m_capb = 0;
      m_rd = 0; m_irq = 0; m_pa = 0; m_pb = 0;
      foreach (m_s1[k]) begin m_s1[k] = 0; m_s2[k] = 0; end
    end else begin
      ev_a  = m_ctrl[1] ? (m_pa == 1 && m_s2[0] == 0) : (m_pa == 0 && m_s2[0] == 1);
      sel_b = m_ctrl[3] ? m_s2[2] : m_s2[1];
      ev_b  = m_ctrl[2] ? (m_pb == 1 && sel_b == 0) : (m_pb == 0 && sel_b == 1);
      unf   = (tick_en && m_cnt == 0);
      case (reg_addr)
        2'd0: m_rd = m_ctrl;
        2'd1: m_rd = m_capa;
        2'd2: m_rd = m_capb;
        default: m_rd = m_cnt;
      endcase
      m_irq = ((m_ctrl[4] | m_ctrl[0]) & m_ctrl[5]) | (m_ctrl[6] & m_ctrl[7]);
      if (reg_we && reg_addr == 2'd0) m_ctrl = int'(reg_wdata[7:0]);
      if (ev_a) begin m_ctrl = m_ctrl | 16; m_capa = m_cnt; end
      if (ev_b) begin m_ctrl = m_ctrl | 64; m_capb = m_cnt; end
      if (unf) m_ctrl = m_ctrl | 1;
      if (tick_en) m_cnt = (m_cnt == 0) ? MASK : m_cnt - 1;
      m_pa = m_s2[0];
      m_pb = sel_b;
      m_s2 = m_s1;
      m_s1[0] = cap_a_pin; m_s1[1] = cap_b_pin; m_s1[2] = cmp_evt;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual %0h expected %0h", label, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check("irq", int'(irq), m_irq);
    check("rdata", int'(reg_rdata), m_rd);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      summary();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input int v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = DATA_W'(v);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    reg_addr = 2'(a);
  endtask

  initial begin
    idle(4);
    label = "R10 reset state";
    check("rdata after reset", int'(reg_rdata), 0);
    check("irq after reset", int'(irq), 0);
    rst = 1'b0;
    rd(3); idle(3);

    label = "R1 count with steady tick";
    tick_en = 1'b1; idle(20);
    label = "R1 count with sparse tick";
    for (int i = 0; i < 30; i++) begin @(negedge clk); tick_en = (i % 3 == 0); end
    tick_en = 1'b1;

    label = "R2 R3 capture A on rising edge";
    wr_ctrl(8'hA0); rd(1);
    @(negedge clk); cap_a_pin = 1'b1; idle(6);
    label = "R3 capture B on rising edge";
    rd(2); @(negedge clk); cap_b_pin = 1'b1; idle(6);
    rd(0); idle(3);

    label = "R4 falling edge select";
    wr_ctrl(8'hA6); rd(1);
    @(negedge clk); cap_a_pin = 1'b0; idle(6);
    @(negedge clk); cap_a_pin = 1'b1; idle(6);
    rd(2); @(negedge clk); cap_b_pin = 1'b0; idle(6);
    rd(0); idle(3);

    label = "R5 clear and sticky flags";
    wr_ctrl(8'hA6); idle(4);
    for (int off = 0; off < 6; off++) begin
      @(negedge clk); cap_a_pin = ~cap_a_pin;
      idle(off);
      wr_ctrl(8'hA6);
      idle(5);
    end

    label = "R8 comparator source for B";
    wr_ctrl(8'h88); rd(2);
    for (int i = 0; i < 4; i++) begin @(negedge clk); cap_b_pin = ~cap_b_pin; idle(5); end
    for (int i = 0; i < 4; i++) begin @(negedge clk); cmp_evt = ~cmp_evt; idle(5); end
    rd(0); idle(3);

    label = "R6 R7 underflow and shared irq";
    wr_ctrl(8'h20); rd(0); idle(300);
    rd(3); idle(260);
    wr_ctrl(8'h00); rd(0); idle(270);
    wr_ctrl(8'h21); idle(5);

    label = "R9 read while capturing";
    rd(1);
    for (int i = 0; i < 8; i++) begin @(negedge clk); cap_a_pin = ~cap_a_pin; idle(i % 4); end
    tick_en = 1'b0; idle(10);
    rd(3); idle(5);

    summary();
  end
endmodule